// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a memory-mapped watchdog. A 10-bit counter is loaded from a programmable reload value and counts down by one on every coarse timebase tick, where one count unit is roughly 21.5 ms. Software must restart the countdown in time by writing a kick bit. A second programmable compare value raises a sticky early-warning interrupt part way through the countdown, so software gets a chance to recover. When the counter reaches zero, the block emits a single-cycle reset request toward the system reset controller.

A reload value of zero switches the whole watchdog off: it neither counts nor raises the interrupt or the reset request. Every register resets to zero, so the block starts disabled. Writing a non-zero reload value while the watchdog is off loads the counter at once and starts it. The coarse timebase comes either from an external tick-enable input or from an internal prescaler; a parameter selects which.

Top module: `wdt_guard`

## Requirements
- R1: After reset, the reload value, the warning threshold and the count all read as zero, and both `warnIrq` and `resetReq` are low.
- R2: While the reload value is zero, ticks leave the count unchanged and neither output asserts. Writing zero to the reload register (word 1) forces the count to zero and clears `warnIrq` in the next cycle.
- R3: Writing a non-zero value to word 1 while the reload value is zero loads that value into the count, and the new count is visible in the next cycle.
- R4: While the reload value is non-zero, each tick on which no register write changes the count lowers the count by exactly one. A count of zero stays at zero.
- R5: Writing a word with bit 0 set to the control register (word 0) reloads the count from the reload value and clears `warnIrq`. Writing a word with bit 0 clear has no effect.
- R6: `warnIrq` sets when a tick lowers the count to the value held in the threshold register (word 2). It then stays set until a kick or a write of zero to word 1.
- R7: The tick that lowers the count from one to zero raises `resetReq` for exactly one cycle. The count then holds at zero.
- R8: Reads are combinational on `regAddr`. Word 3 returns the count with all bits above bit 9 zero. Word 1 and word 2 return their stored 10-bit values. Word 0 reads as zero. Write data bits above bit 9 are ignored.
- R9: A non-zero write to word 1 while the watchdog is running changes only the stored reload value. The count carries on unchanged until the next kick.
- R10: A kick that coincides with a tick reloads the count, and that tick is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | External timebase tick, or the prescaler enable in internal mode |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Word address: 0 control, 1 reload, 2 threshold, 3 count |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr` |
| warnIrq | output | 1 | Sticky early-warning interrupt |
| resetReq | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with `EXT_TICK = 1`, so the bench drives every tick directly and can place it on any chosen cycle, instead of waiting about 21.5 ms of clock for each one. It uses reload values no larger than 15. With these values, expiry, threshold hits, a kick landing on the same cycle as a tick, and restarts from the disabled state each occur within a few dozen cycles. A random phase with a fixed seed therefore reaches every one of these cases many times.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_WARN   = 2'd2,
    REG_COUNT  = 2'd3
  } wdt_reg_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;   // load counter from loadVal, clear warning
    logic stop;   // force counter to zero, clear warning
    logic tick;   // decrement request (watchdog enabled)
  } wdt_strb_t;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter bit          EXT_TICK = 1'b0,
  parameter int unsigned DIV      = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  output logic tickOut
);
  generate
    if (EXT_TICK) begin : g_ext
      assign tickOut = tickEn;
    end else begin : g_pre
      localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) preCnt <= '0;
        else if (tickEn) preCnt <= (preCnt == LAST) ? '0 : preCnt + 1'b1;
      end
      assign tickOut = tickEn && (preCnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickRaw,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  loadVal,
  output wdt_strb_t         strb,
  output logic [DATA_W-1:0] rdData
);
  logic [CNT_W-1:0] reloadQ, warnQ;
  logic [CNT_W-1:0] newVal;
  logic kickWr, reloadWr, warnWr, enabled;

  assign newVal   = wrData[CNT_W-1:0];
  assign enabled  = (reloadQ != '0);
  assign kickWr   = wrEn && (regAddr == REG_CTRL) && wrData[0];
  assign reloadWr = wrEn && (regAddr == REG_RELOAD);
  assign warnWr   = wrEn && (regAddr == REG_WARN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
      warnQ   <= '0;
    end else begin
      if (reloadWr) reloadQ <= newVal;
      if (warnWr)   warnQ   <= newVal;
    end
  end

  always_comb begin
    strb      = '0;
    loadVal   = reloadQ;
    strb.tick = tickRaw && enabled;
    if (kickWr) begin
      strb.load = 1'b1;
    end else if (reloadWr && newVal == '0) begin
      strb.stop = 1'b1;
    end else if (reloadWr && !enabled) begin
      strb.load = 1'b1;
      loadVal   = newVal;
    end
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      REG_RELOAD: rdData[CNT_W-1:0] = reloadQ;
      REG_WARN:   rdData[CNT_W-1:0] = warnQ;
      REG_COUNT:  rdData[CNT_W-1:0] = count;
      default:    rdData = '0;
    endcase
  end

  // R9
  reload_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    reloadWr |=> reloadQ == $past(newVal));
  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !reloadWr && !kickWr) |=> count == $past(count));
endmodule

// File: rtl/wdt_dpath.sv
module wdt_dpath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdt_strb_t        strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] warnVal,
  output logic [CNT_W-1:0] count,
  output logic             warnIrq,
  output logic             resetReq
);
  logic [CNT_W-1:0] nextDown;
  assign nextDown = count - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      warnIrq  <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= 1'b0;
      if (strb.stop) begin
        count   <= '0;
        warnIrq <= 1'b0;
      end else if (strb.load) begin
        count   <= loadVal;
        warnIrq <= 1'b0;
      end else if (strb.tick && count != '0) begin
        count <= nextDown;
        if (nextDown == warnVal) warnIrq <= 1'b1;
        if (nextDown == '0) resetReq <= 1'b1;
      end
    end
  end

  // R7
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  // R7
  reset_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> count == '0);
  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.stop) |=>
      (count == $past(count) || count == $past(count) - 1'b1));
  // R6
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warnIrq && !strb.load && !strb.stop) |=> warnIrq);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int          CNT_W    = 10,
  parameter int          DATA_W   = 32,
  parameter bit          EXT_TICK = 1'b0,
  parameter int unsigned DIV      = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              warnIrq,
  output logic              resetReq
);
  logic             tickRaw;
  wdt_strb_t        strb;
  logic [CNT_W-1:0] loadVal, count, warnVal;

  wdt_tick_gen #(.EXT_TICK(EXT_TICK), .DIV(DIV)) tick_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .tickOut(tickRaw));

  wdt_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .tickRaw(tickRaw), .count(count), .loadVal(loadVal), .strb(strb),
    .rdData(rdData));

  assign warnVal = ctrl_i.warnQ;

  wdt_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .warnVal(warnVal),
    .count(count), .warnIrq(warnIrq), .resetReq(resetReq));

  // R5
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == REG_CTRL && wrData[0]) |=> (count == $past(ctrl_i.reloadQ) && !warnIrq));
endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, wrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        warnIrq, resetReq;

  int checks = 0, failures = 0;
  logic [9:0] mReload = '0, mThr = '0, mCount = '0;
  logic       mIrq = 1'b0, mRst = 1'b0;

  always #2 clk = ~clk;

  wdt_guard #(.CNT_W(10), .DATA_W(32), .EXT_TICK(1'b1), .DIV(4)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .warnIrq(warnIrq), .resetReq(resetReq));

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      2'd1: return {22'd0, mReload};
      2'd2: return {22'd0, mThr};
      2'd3: return {22'd0, mCount};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic we, input logic [1:0] a, input logic [31:0] d, input logic t);
    logic [9:0] nv;
    nv = d[9:0];
    mRst = 1'b0;
    if (we && a == 2'd0 && d[0]) begin
      mCount = mReload; mIrq = 1'b0;
    end else if (we && a == 2'd1 && nv == 10'd0) begin
      mCount = 10'd0; mIrq = 1'b0;
    end else if (we && a == 2'd1 && mReload == 10'd0) begin
      mCount = nv; mIrq = 1'b0;
    end else if (t && mReload != 10'd0 && mCount != 10'd0) begin
      mCount = mCount - 10'd1;
      if (mCount == mThr) mIrq = 1'b1;
      if (mCount == 10'd0) mRst = 1'b1;
    end
    if (we && a == 2'd1) mReload = nv;
    if (we && a == 2'd2) mThr = nv;
  endtask

  // One cycle: drive, model at the edge, compare at the following negedge
  task automatic step(input string tag, input logic we, input logic [1:0] a,
                      input logic [31:0] d, input logic t);
    wrEn = we; regAddr = a; wrData = d; tickEn = t;
    @(posedge clk);
    modelStep(we, a, d, t);
    @(negedge clk);
    check({tag, " irq"}, {31'd0, warnIrq}, {31'd0, mIrq});
    check({tag, " rst"}, {31'd0, resetReq}, {31'd0, mRst});
    check({tag, " rd"}, rdData, expRead(a));
  endtask

  task automatic rd(input string tag, input logic [1:0] a);
    step(tag, 1'b0, a, 32'd0, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd("R1 ctrl", 2'd0); rd("R1 reload", 2'd1); rd("R1 warn", 2'd2); rd("R1 count", 2'd3);
    // R2 ticks while disabled
    repeat (3) step("R2 disabled tick", 1'b0, 2'd3, 32'd0, 1'b1);
    // R8 upper write bits ignored
    step("R8 warn write", 1'b1, 2'd2, 32'hFFFF_F003, 1'b0);
    rd("R8 warn read", 2'd2);
    // R3 start from disabled
    step("R3 start", 1'b1, 2'd1, 32'd6, 1'b1);
    rd("R3 count", 2'd3);
    // R4 / R6 / R7 countdown to expiry
    repeat (3) step("R4 R6 down", 1'b0, 2'd3, 32'd0, 1'b1);
    step("R4 idle", 1'b0, 2'd3, 32'd0, 1'b0);
    repeat (3) step("R6 R7 expiry", 1'b0, 2'd3, 32'd0, 1'b1);
    repeat (2) step("R7 hold zero", 1'b0, 2'd3, 32'd0, 1'b1);
    // R5 kick with bit0 clear, then set
    step("R5 no kick", 1'b1, 2'd0, 32'hFFFF_FFFE, 1'b0);
    rd("R5 after zero write", 2'd3);
    step("R5 kick", 1'b1, 2'd0, 32'd1, 1'b0);
    rd("R5 count", 2'd3);
    // R9 reload write while running
    step("R9 new reload", 1'b1, 2'd1, 32'd9, 1'b0);
    rd("R9 count unchanged", 2'd3);
    step("R9 tick", 1'b0, 2'd3, 32'd0, 1'b1);
    // R10 kick with tick
    step("R10 kick+tick", 1'b1, 2'd0, 32'd1, 1'b1);
    rd("R10 count", 2'd3);
    // R2 disable
    step("R2 disable", 1'b1, 2'd1, 32'd0, 1'b0);
    repeat (2) step("R2 off tick", 1'b0, 2'd3, 32'd0, 1'b1);
    rd("R2 reload read", 2'd1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [31:0] d;
      logic [1:0] a;
      logic we;
      r = $urandom_range(0, 99);
      d = $urandom;
      we = 1'b1;
      if (r < 8) begin a = 2'd0; end
      else if (r < 13) begin a = 2'd1; d = (d & 32'hFFFF_FC00) | 32'($urandom_range(0, 15)); end
      else if (r < 17) begin a = 2'd2; d = (d & 32'hFFFF_FC00) | 32'($urandom_range(0, 15)); end
      else begin we = 1'b0; a = 2'($urandom_range(0, 3)); end
      step("RND R4 R6 R7 R8", we, a, d, 1'($urandom_range(0, 1)));
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule